// File: doc/BRIEF.md
# SPI Slave Interrupt Event Generator

This block sits beside an SPI slave serializer and its DMA engine and condenses their status into a single maskable interrupt line. It watches three status bits (transmit idle, transmit FIFO has room, receive FIFO holds data), the active flags of the two transmit and two receive DMA buffers, and two one-cycle error pulses (receive overrun, transmit underrun). Each of these nine sources owns one sticky event flag.

A mode input decides how the three status sources trigger. In edge mode a flag is raised on a 0-to-1 change of the status bit. In level mode it is raised on every cycle in which the bit is high. DMA buffer completion is always taken from the 1-to-0 change of that buffer's active flag, whatever the mode. Software clears flags by writing ones into a clear vector. The registered interrupt output is high when any flag whose enable bit is set is high.

The reset input is asserted asynchronously and released synchronously to the clock by a short synchronizer inside the block.

Top module: `spi_slave_irq`

## Requirements
- R1: In the cycles after reset is released, all nine flags and the interrupt output are 0.
- R2: With `level_mode` at 0, a 0-to-1 change of `tx_idle`, `tx_free` or `rx_valid` sets flag bit 0, 1 or 2 once. A 1-to-0 change sets nothing. After that flag is cleared, it stays clear while the status bit stays high.
- R3: With `level_mode` at 1, flag bits 0 to 2 are set on every clock edge at which the matching status bit is high, so a clear has no lasting effect while the bit is high.
- R4: A status bit that is already high when reset is released does not count as a 0-to-1 change in edge mode.
- R5: A 1-to-0 change of a DMA active flag sets one flag: transmit A sets bit 3, transmit B sets bit 4, receive A sets bit 5 and receive B sets bit 6. A 0-to-1 change of a DMA active flag sets nothing. This holds in both modes.
- R6: A cycle with `rx_overrun` high sets flag bit 7. A cycle with `tx_underrun` high sets flag bit 8.
- R7: Flags are sticky. A 1 in bit i of `flag_clr` clears flag i at the next edge. Flags whose `flag_clr` bit is 0 keep their value.
- R8: When an event and a clear of the same flag fall on the same edge, the flag ends up set.
- R9: `irq` is a register that holds the OR of (flags AND `irq_en`) from the previous cycle. It rises one cycle after the flag appears, and it stays 0 while every set flag is masked.
- R10: Flags are set whether or not their enable bit is set. Changing `irq_en` affects `irq` one cycle later and leaves the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| level_mode | input | 1 | 1 selects level triggering for the status sources, 0 selects rising-edge triggering |
| tx_idle | input | 1 | Transmit FIFO empty and last character shifted out |
| tx_free | input | 1 | Transmit FIFO not full |
| rx_valid | input | 1 | Receive FIFO not empty |
| txdma_act | input | 2 | Transmit DMA buffer active flags, bit 0 = A, bit 1 = B |
| rxdma_act | input | 2 | Receive DMA buffer active flags, bit 0 = A, bit 1 = B |
| rx_overrun | input | 1 | Pulse: character lost because the receive FIFO was full |
| tx_underrun | input | 1 | Pulse: character sent while the transmit FIFO was empty |
| irq_en | input | 9 | Per-flag interrupt enable |
| flag_clr | input | 9 | Write-1-to-clear strobe per flag |
| flags | output | 9 | Sticky event flags |
| irq | output | 1 | Registered interrupt request |

## Verification
The hardest cases to reach from the ports are a clear that lands on the same clock edge as a fresh event, and a level-mode source that keeps raising its flag through a clear. In both cases the flag looks unchanged from outside. The bench therefore drives the clear vector and the error pulses, or the held status bits, on the same falling edge, so that both reach the design at one rising edge. It then reads the flags one cycle later and once more after the stimulus is removed. Holding all three status bits high across the release of reset shows that a bit already high at reset is not treated as a rising edge.

// File: rtl/sirq_pkg.sv
`timescale 1ns/1ps
package sirq_pkg;
  localparam int N_STS  = 3;
  localparam int N_DMA  = 4;
  localparam int N_ERR  = 2;
  localparam int EV_W   = N_STS + N_DMA + N_ERR;

  localparam int EV_TXIDLE = 0;
  localparam int EV_TXFREE = 1;
  localparam int EV_RXVAL  = 2;
  localparam int EV_DMA0   = N_STS;
  localparam int EV_ERR0   = N_STS + N_DMA;
  localparam int EV_OVR    = EV_ERR0;
  localparam int EV_UND    = EV_ERR0 + 1;
endpackage

// File: rtl/sirq_rst_sync.sv
`timescale 1ns/1ps
module sirq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/sirq_detect.sv
`timescale 1ns/1ps
module sirq_detect
  import sirq_pkg::*;
#(
  parameter int NS = N_STS,
  parameter int ND = N_DMA,
  parameter int NE = N_ERR,
  localparam int W = NS + ND + NE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          level_mode,
  input  logic [NS-1:0] sts_i,
  input  logic [ND-1:0] dma_i,
  input  logic [NE-1:0] err_i,
  output logic [W-1:0]  ev_o,
  output logic [ND-1:0] dma_prev_o
);
  logic [NS-1:0] sts_prev_q, sts_prev_d;
  logic [ND-1:0] dma_prev_q, dma_prev_d;
  logic          prev_en;

  // history follows the inputs every cycle
  always_comb begin
    prev_en    = 1'b1;
    sts_prev_d = sts_i;
    dma_prev_d = dma_i;
  end

  // status history resets high so a bit already high at release is no edge (R4)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_prev_q <= '1;
      dma_prev_q <= '0;
    end else if (prev_en) begin
      sts_prev_q <= sts_prev_d;
      dma_prev_q <= dma_prev_d;
    end
  end

  for (genvar s = 0; s < NS; s++) begin : g_sts
    always_comb begin
      if (level_mode) ev_o[s] = sts_i[s];
      else            ev_o[s] = sts_i[s] & ~sts_prev_q[s];
    end
  end

  for (genvar d = 0; d < ND; d++) begin : g_dma
    assign ev_o[NS + d] = dma_prev_q[d] & ~dma_i[d];
  end

  for (genvar e = 0; e < NE; e++) begin : g_err
    assign ev_o[NS + ND + e] = err_i[e];
  end

  assign dma_prev_o = dma_prev_q;

  for (genvar s = 0; s < NS; s++) begin : g_sts_chk
    AST_EDGE_NEEDS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      (!level_mode && ev_o[s]) |=> sts_prev_q[s]) else $error("edge event without rise"); // R2
  end
endmodule

// File: rtl/sirq_flags.sv
`timescale 1ns/1ps
module sirq_flags #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] ev_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] flags_o
);
  logic [W-1:0] flag_q, flag_d, flag_en;

  // an event overrides a clear of the same bit (R8)
  always_comb begin
    flag_en = ev_i | clr_i;
    flag_d  = (flag_q & ~clr_i) | ev_i;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flag_q[i] <= 1'b0;
      else if (flag_en[i]) flag_q[i] <= flag_d[i];
    end

    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      ev_i[i] |=> flag_q[i]) else $error("event lost"); // R8
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[i] && !ev_i[i]) |=> !flag_q[i]) else $error("clear ignored"); // R7
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[i] && !clr_i[i]) |=> flag_q[i]) else $error("flag dropped"); // R7
  end

  assign flags_o = flag_q;
endmodule

// File: rtl/sirq_merge.sv
`timescale 1ns/1ps
module sirq_merge #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] flags_i,
  input  logic [W-1:0] en_i,
  output logic         irq_o
);
  logic irq_q, irq_d, irq_upd;

  always_comb begin
    irq_upd = 1'b1;
    irq_d   = |(flags_i & en_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       irq_q <= 1'b0;
    else if (irq_upd) irq_q <= irq_d;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/spi_slave_irq.sv
`timescale 1ns/1ps
module spi_slave_irq
  import sirq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            level_mode,
  input  logic            tx_idle,
  input  logic            tx_free,
  input  logic            rx_valid,
  input  logic [1:0]      txdma_act,
  input  logic [1:0]      rxdma_act,
  input  logic            rx_overrun,
  input  logic            tx_underrun,
  input  logic [EV_W-1:0] irq_en,
  input  logic [EV_W-1:0] flag_clr,
  output logic [EV_W-1:0] flags,
  output logic            irq
);
  logic             rst_int_n;
  logic [N_STS-1:0] sts;
  logic [N_DMA-1:0] dma;
  logic [N_ERR-1:0] err;
  logic [EV_W-1:0]  ev;
  logic [N_DMA-1:0] dma_prev;

  assign sts = {rx_valid, tx_free, tx_idle};
  assign dma = {rxdma_act, txdma_act};
  assign err = {tx_underrun, rx_overrun};

  sirq_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n)
  );

  sirq_detect #(.NS(N_STS), .ND(N_DMA), .NE(N_ERR)) u_det (
    .clk(clk), .rst_n(rst_int_n), .level_mode(level_mode),
    .sts_i(sts), .dma_i(dma), .err_i(err),
    .ev_o(ev), .dma_prev_o(dma_prev)
  );

  sirq_flags #(.W(EV_W)) u_flg (
    .clk(clk), .rst_n(rst_int_n), .ev_i(ev), .clr_i(flag_clr), .flags_o(flags)
  );

  sirq_merge #(.W(EV_W)) u_mrg (
    .clk(clk), .rst_n(rst_int_n), .flags_i(flags), .en_i(irq_en), .irq_o(irq)
  );

  AST_LEVEL_REFIRES: assert property (@(posedge clk) disable iff (!rst_int_n)
    (level_mode && tx_idle) |=> flags[EV_TXIDLE]) else $error("level miss"); // R3
  AST_OVERRUN_SETS: assert property (@(posedge clk) disable iff (!rst_int_n)
    rx_overrun |=> flags[EV_OVR]) else $error("overrun miss"); // R6
  AST_UNDERRUN_SETS: assert property (@(posedge clk) disable iff (!rst_int_n)
    tx_underrun |=> flags[EV_UND]) else $error("underrun miss"); // R6
  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_int_n)
    (|(flags & irq_en)) |=> irq) else $error("irq missing"); // R9
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_int_n)
    ((flags & irq_en) == '0) |=> !irq) else $error("irq spurious"); // R9

  for (genvar d = 0; d < N_DMA; d++) begin : g_dma_chk
    AST_DMA_FALL: assert property (@(posedge clk) disable iff (!rst_int_n)
      (dma_prev[d] && !dma[d]) |=> flags[EV_DMA0 + d]) else $error("dma miss"); // R5
  end
endmodule

// File: tb/spi_slave_irq_test.sv
`timescale 1ns/1ps
module spi_slave_irq_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       level_mode;
  logic [2:0] sts;
  logic [3:0] dma;
  logic       rx_overrun, tx_underrun;
  logic [8:0] irq_en, flag_clr;
  logic [8:0] flags;
  logic       irq;
  int         checks = 0;
  int         errors = 0;
  bit         done = 0;

  always #2.5 clk = ~clk;

  spi_slave_irq uut (
    .clk(clk), .rst_n(rst_n), .level_mode(level_mode),
    .tx_idle(sts[0]), .tx_free(sts[1]), .rx_valid(sts[2]),
    .txdma_act(dma[1:0]), .rxdma_act(dma[3:2]),
    .rx_overrun(rx_overrun), .tx_underrun(tx_underrun),
    .irq_en(irq_en), .flag_clr(flag_clr), .flags(flags), .irq(irq)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear(input logic [8:0] m);
    flag_clr = m;
    tick();
    flag_clr = '0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; level_mode = 1'b0; sts = 3'b111; dma = '0;
    rx_overrun = 1'b0; tx_underrun = 1'b0; irq_en = '0; flag_clr = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (5) tick();
    check("R1 flags after reset, R4 high status no edge", flags, 9'h000);
    check("R1 irq after reset", {8'd0, irq}, 9'h000);
  endtask

  task automatic t_edge();
    for (int i = 0; i < 3; i++) begin
      sts[i] = 1'b0; tick();
      check("R2 falling status sets nothing", flags, 9'h000);
      sts[i] = 1'b1; tick();
      check("R2 rising status sets flag", flags, 9'(1 << i));
      tick(); tick();
      clear(9'(1 << i));
      check("R2 cleared while held high", flags, 9'h000);
      tick();
      check("R2 no retrigger while high", flags, 9'h000);
    end
  endtask

  task automatic t_level();
    level_mode = 1'b1; tick();
    check("R3 level sets all status flags", flags, 9'h007);
    clear(9'h007);
    check("R3 level reasserts through clear", flags, 9'h007);
    sts = 3'b000; tick();
    clear(9'h007);
    check("R3 clear works once status low", flags, 9'h000);
    level_mode = 1'b0;
  endtask

  task automatic t_dma(input logic mode);
    level_mode = mode;
    for (int i = 0; i < 4; i++) begin
      dma[i] = 1'b1; tick();
      check("R5 dma rise sets nothing", flags, 9'h000);
      dma[i] = 1'b0; tick();
      check("R5 dma fall sets flag", flags, 9'(1 << (3 + i)));
      tick();
      check("R5 single event sticky", flags, 9'(1 << (3 + i)));
      clear(9'(1 << (3 + i)));
    end
    level_mode = 1'b0;
  endtask

  task automatic t_err();
    rx_overrun = 1'b1; tick(); rx_overrun = 1'b0;
    check("R6 overrun sets bit 7", flags, 9'h080);
    tick();
    check("R7 overrun flag sticky", flags, 9'h080);
    tx_underrun = 1'b1; tick(); tx_underrun = 1'b0;
    check("R6 underrun sets bit 8", flags, 9'h180);
    clear(9'h000);
    check("R7 zero clear keeps flags", flags, 9'h180);
    clear(9'h080);
    check("R7 partial clear", flags, 9'h100);
    clear(9'h100);
    check("R7 final clear", flags, 9'h000);
  endtask

  task automatic t_race();
    rx_overrun = 1'b1; tick(); rx_overrun = 1'b0;
    flag_clr = 9'h180; rx_overrun = 1'b1; tx_underrun = 1'b1;
    tick();
    flag_clr = '0; rx_overrun = 1'b0; tx_underrun = 1'b0;
    check("R8 event beats clear", flags, 9'h180);
    tick();
    check("R8 flags remain after race", flags, 9'h180);
    clear(9'h180);
    check("R8 later clear works", flags, 9'h000);
  endtask

  task automatic t_irq();
    irq_en = '0;
    rx_overrun = 1'b1; tick(); rx_overrun = 1'b0;
    check("R10 flag set while disabled", flags, 9'h080);
    tick();
    check("R9 masked flag no irq", {8'd0, irq}, 9'h000);
    irq_en = 9'h100; tick(); tick();
    check("R9 other enable no irq", {8'd0, irq}, 9'h000);
    irq_en = 9'h080; tick();
    check("R10 enable raises irq next cycle", {8'd0, irq}, 9'h001);
    irq_en = 9'h000; tick();
    check("R10 disable drops irq", {8'd0, irq}, 9'h000);
    check("R10 flags untouched by enable", flags, 9'h080);
    irq_en = 9'h080; tick();
    clear(9'h080);
    check("R9 flag cleared", flags, 9'h000);
    check("R9 irq lags clear by one cycle", {8'd0, irq}, 9'h001);
    tick();
    check("R9 irq drops after clear", {8'd0, irq}, 9'h000);
    irq_en = 9'h1FF;
    tx_underrun = 1'b1; tick(); tx_underrun = 1'b0;
    check("R9 flag appears first", flags, 9'h100);
    check("R9 irq not yet high", {8'd0, irq}, 9'h000);
    tick();
    check("R9 irq one cycle after flag", {8'd0, irq}, 9'h001);
    clear(9'h100); tick();
    check("R9 irq low after final clear", {8'd0, irq}, 9'h000);
  endtask

  initial begin
    t_reset();
    t_edge();
    t_level();
    t_dma(1'b0);
    t_dma(1'b1);
    t_err();
    t_race();
    t_irq();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule